// File: doc/BRIEF.md
# Video Memory Block-Transfer Engine

This block moves runs of 16-bit words into a video memory without CPU involvement. Software programs a word count, a source word address and a transfer type through a small byte-wide register port. It then issues a start command that carries the destination address. Three kinds of transfer exist. A bus copy reads words from the host bus and writes them to video memory. A fill writes one data word repeatedly. A video copy reads from video memory and writes back into video memory.

The engine drives three independent request/acknowledge ports: a host-bus read port, a video-memory read port and a video-memory write port. Each port holds its request until the far side acknowledges. The destination advances by a programmable step after every word. The count and source registers track the transfer as it runs and show their final values once it ends. A busy output covers the whole run. Start commands are honoured only while the global enable bit is set.

Top module: `vdma_engine`

## Requirements
- R1: The word count is {reg 0x14, reg 0x13} (high byte, low byte). A count of zero moves 65536 words.
- R2: The source word address is {reg 0x17 bits 6..0, reg 0x16, reg 0x15}, 23 bits. Reg 0x17 bits 7..6 give the type: 0x is a bus copy, where bit 6 is source bit 22; 10 is a fill; 11 is a video copy.
- R3: A start command (`cmd_we`) is accepted only while bit 4 of reg 0x01 is 1. Otherwise it is ignored: busy stays 0 and no write is issued.
- R4: `busy` is 1 from the cycle after an accepted start until the acknowledge of the last write. A start command that arrives while busy is ignored.
- R5: The n-th word written (counting from 0) goes to `cmd_dest + n*reg 0x0F`, modulo 2^16.
- R6: A bus copy reads `haddr` = source, then source+1, and so on. The increment wraps within bits 21..0 and leaves bit 22 unchanged. Each word read is written unchanged.
- R7: A fill issues no write until `data_we` supplies the fill word, then writes that word count times. `data_we` has no effect at any other time.
- R8: A video copy reads `vaddr` = source bits 15..0, incremented modulo 2^16 per word, and writes each word read.
- R9: After a transfer, the count registers read 0. The source reads its start value plus the count: within bits 21..0 for a bus copy, within bits 15..0 for a video copy, and unchanged for a fill.
- R10: Register writes to 0x13..0x17 while busy have no effect.
- R11: Each request stays high with stable address and data until it is acknowledged. At most one of `hreq`, `vreq` and `wreq` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write index |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 5 | Register read index |
| reg_rdata | output | 8 | Register read data (combinational) |
| cmd_we | input | 1 | Start command |
| cmd_dest | input | 16 | Destination address for the start command |
| data_we | input | 1 | Data port write (fill word) |
| data_wdata | input | 16 | Data port value |
| busy | output | 1 | Transfer in progress |
| hreq | output | 1 | Host-bus read request |
| haddr | output | 23 | Host-bus word address |
| hack | input | 1 | Host-bus read acknowledge |
| hrdata | input | 16 | Host-bus read data |
| vreq | output | 1 | Video-memory read request |
| vaddr | output | 16 | Video-memory read address |
| vack | input | 1 | Video-memory read acknowledge |
| vrdata | input | 16 | Video-memory read data |
| wreq | output | 1 | Video-memory write request |
| waddr | output | 16 | Video-memory write address |
| wdata | output | 16 | Video-memory write data |
| wack | input | 1 | Video-memory write acknowledge |

## Verification
A CPU write to a count or source register can land in the same cycle as the acknowledge of a word, when the engine decrements the count and advances the source itself. The bench provokes this by writing random values to reg 0x13 on random cycles during about half of the transfers, while the memory responders acknowledge with random delays. Success means the number of words written and the final count and source values match what the bench computes from the programmed values alone.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int LEN_W  = 16;
  localparam int SRC_W  = 23;
  localparam int DATA_W = 16;
  localparam int DST_W  = 16;
  localparam int RA_W   = 5;

  localparam logic [RA_W-1:0] RA_MODE2 = 5'h01;
  localparam logic [RA_W-1:0] RA_STEP  = 5'h0F;
  localparam logic [RA_W-1:0] RA_LENL  = 5'h13;
  localparam logic [RA_W-1:0] RA_LENH  = 5'h14;
  localparam logic [RA_W-1:0] RA_SRCL  = 5'h15;
  localparam logic [RA_W-1:0] RA_SRCM  = 5'h16;
  localparam logic [RA_W-1:0] RA_SRCH  = 5'h17;
  localparam int EN_BIT = 4;

  typedef enum logic [1:0] {XM_BUS, XM_FILL, XM_VCOPY} xfer_mode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM, SQ_RD, SQ_WR} seq_state_e;

  function automatic xfer_mode_e decode_mode(input logic t1, input logic t0);
    if (!t1)     return XM_BUS;
    else if (!t0) return XM_FILL;
    else          return XM_VCOPY;
  endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [RA_W-1:0]   reg_raddr,
  output logic [7:0]        reg_rdata,
  input  logic              busy,
  input  logic              word_done,
  output logic              dma_en,
  output logic [7:0]        step,
  output logic [LEN_W-1:0]  len,
  output logic [SRC_W-1:0]  src,
  output xfer_mode_e        mode
);
  logic [7:0]       mode2_q, mode2_d;
  logic [7:0]       step_q, step_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             thi_q, thi_d;
  logic             xfer_reg;
  logic             wr_ok;

  assign xfer_reg = (reg_addr >= RA_LENL) && (reg_addr <= RA_SRCH);
  assign wr_ok    = reg_we && !(busy && xfer_reg);
  assign mode     = decode_mode(thi_q, src_q[SRC_W-1]);

  always_comb begin
    mode2_d = mode2_q;
    step_d  = step_q;
    len_d   = len_q;
    src_d   = src_q;
    thi_d   = thi_q;
    if (wr_ok) begin
      case (reg_addr)
        RA_MODE2: mode2_d = reg_wdata;
        RA_STEP:  step_d  = reg_wdata;
        RA_LENL:  len_d[7:0]  = reg_wdata;
        RA_LENH:  len_d[15:8] = reg_wdata;
        RA_SRCL:  src_d[7:0]  = reg_wdata;
        RA_SRCM:  src_d[15:8] = reg_wdata;
        RA_SRCH:  begin
          thi_d = reg_wdata[7];
          src_d[SRC_W-1:16] = reg_wdata[6:0];
        end
        default: ;
      endcase
    end
    if (word_done) begin
      len_d = len_q - LEN_W'(1);
      case (mode)
        XM_BUS:   src_d[SRC_W-2:0] = src_q[SRC_W-2:0] + (SRC_W-1)'(1);
        XM_VCOPY: src_d[15:0]      = src_q[15:0] + 16'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode2_q <= '0;
      step_q  <= '0;
      len_q   <= '0;
      src_q   <= '0;
      thi_q   <= 1'b0;
    end else begin
      mode2_q <= mode2_d;
      step_q  <= step_d;
      len_q   <= len_d;
      src_q   <= src_d;
      thi_q   <= thi_d;
    end
  end

  always_comb begin
    case (reg_raddr)
      RA_MODE2: reg_rdata = mode2_q;
      RA_STEP:  reg_rdata = step_q;
      RA_LENL:  reg_rdata = len_q[7:0];
      RA_LENH:  reg_rdata = len_q[15:8];
      RA_SRCL:  reg_rdata = src_q[7:0];
      RA_SRCM:  reg_rdata = src_q[15:8];
      RA_SRCH:  reg_rdata = {thi_q, src_q[SRC_W-1:16]};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign dma_en = mode2_q[EN_BIT];
  assign step   = step_q;
  assign len    = len_q;
  assign src    = src_q;

  // R10
  lenlo_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy && reg_addr == RA_LENL && !word_done) |=> $stable(len_q));
  // R10
  src_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy && reg_addr == RA_SRCH && !word_done) |=> $stable(src_q) && $stable(thi_q));
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic [7:0]        step,
  input  logic [LEN_W-1:0]  len,
  input  logic [SRC_W-1:0]  src,
  input  xfer_mode_e        mode,
  input  logic              cmd_we,
  input  logic [DST_W-1:0]  cmd_dest,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  output logic              busy,
  output logic              word_done,
  output logic              hreq,
  output logic [SRC_W-1:0]  haddr,
  input  logic              hack,
  input  logic [DATA_W-1:0] hrdata,
  output logic              vreq,
  output logic [DST_W-1:0]  vaddr,
  input  logic              vack,
  input  logic [DATA_W-1:0] vrdata,
  output logic              wreq,
  output logic [DST_W-1:0]  waddr,
  output logic [DATA_W-1:0] wdata,
  input  logic              wack
);
  seq_state_e        st_q, st_d;
  logic [DST_W-1:0]  dest_q, dest_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              last;

  assign last  = (len == LEN_W'(1));
  assign busy  = (st_q != SQ_IDLE);
  assign hreq  = (st_q == SQ_RD) && (mode == XM_BUS);
  assign vreq  = (st_q == SQ_RD) && (mode == XM_VCOPY);
  assign wreq  = (st_q == SQ_WR);
  assign haddr = src;
  assign vaddr = src[DST_W-1:0];
  assign waddr = dest_q;
  assign wdata = data_q;

  always_comb begin
    st_d      = st_q;
    dest_d    = dest_q;
    data_d    = data_q;
    word_done = 1'b0;
    case (st_q)
      SQ_IDLE: if (cmd_we && dma_en) begin
        dest_d = cmd_dest;
        st_d   = (mode == XM_FILL) ? SQ_ARM : SQ_RD;
      end
      SQ_ARM: if (data_we) begin
        data_d = data_wdata;
        st_d   = SQ_WR;
      end
      SQ_RD: begin
        if (hreq && hack) begin
          data_d = hrdata;
          st_d   = SQ_WR;
        end else if (vreq && vack) begin
          data_d = vrdata;
          st_d   = SQ_WR;
        end
      end
      SQ_WR: if (wack) begin
        word_done = 1'b1;
        dest_d    = dest_q + DST_W'(step);
        if (last)                 st_d = SQ_IDLE;
        else if (mode == XM_FILL) st_d = SQ_WR;
        else                      st_d = SQ_RD;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      dest_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      dest_q <= dest_d;
      data_q <= data_d;
    end
  end

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq && !wack) |=> (wreq && $stable(waddr) && $stable(wdata)));
  // R11
  hrd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && !hack) |=> (hreq && $stable(haddr)));
  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hreq, vreq, wreq}));
  // R7
  fill_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ARM && !data_we) |=> !wreq);
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [4:0]        reg_raddr,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_we,
  input  logic [15:0]       cmd_dest,
  input  logic              data_we,
  input  logic [15:0]       data_wdata,
  output logic              busy,
  output logic              hreq,
  output logic [22:0]       haddr,
  input  logic              hack,
  input  logic [15:0]       hrdata,
  output logic              vreq,
  output logic [15:0]       vaddr,
  input  logic              vack,
  input  logic [15:0]       vrdata,
  output logic              wreq,
  output logic [15:0]       waddr,
  output logic [15:0]       wdata,
  input  logic              wack
);
  logic [1:0]       rst_pipe_q;
  logic             rst_i_n;
  logic             dma_en;
  logic             word_done;
  logic [7:0]       step;
  logic [LEN_W-1:0] len;
  logic [SRC_W-1:0] src;
  xfer_mode_e       mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  vdma_regs u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busy(busy), .word_done(word_done),
    .dma_en(dma_en), .step(step), .len(len), .src(src), .mode(mode)
  );

  vdma_seq u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .dma_en(dma_en), .step(step), .len(len), .src(src), .mode(mode),
    .cmd_we(cmd_we), .cmd_dest(cmd_dest),
    .data_we(data_we), .data_wdata(data_wdata),
    .busy(busy), .word_done(word_done),
    .hreq(hreq), .haddr(haddr), .hack(hack), .hrdata(hrdata),
    .vreq(vreq), .vaddr(vaddr), .vack(vack), .vrdata(vrdata),
    .wreq(wreq), .waddr(waddr), .wdata(wdata), .wack(wack)
  );

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && !dma_en && !busy) |=> !busy);
endmodule

// File: tb/sim_vdma_engine.sv
`timescale 1ns/1ps
module sim_vdma_engine;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_we; logic [4:0] reg_addr; logic [7:0] reg_wdata;
  logic [4:0] reg_raddr; logic [7:0] reg_rdata;
  logic cmd_we; logic [15:0] cmd_dest;
  logic data_we; logic [15:0] data_wdata;
  logic busy;
  logic hreq; logic [22:0] haddr; logic hack; logic [15:0] hrdata;
  logic vreq; logic [15:0] vaddr; logic vack; logic [15:0] vrdata;
  logic wreq; logic [15:0] waddr; logic [15:0] wdata; logic wack;

  always #4 clk = ~clk;

  vdma_engine u0 (.*);

  int total = 0, bad = 0, cycles = 0;
  int ack_pct = 60;
  int idx = 0, werr = 0, wr_count = 0;
  int e_mode;  // 0 bus, 1 fill, 2 vcopy
  logic [15:0] e_dest, e_fill; logic [7:0] e_step; logic [22:0] e_src;

  function automatic logic [15:0] hfun(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], a[8:0]} ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] vfun(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3E1;
  endfunction
  function automatic logic [15:0] exp_addr(input int n);
    return e_dest + 16'(n) * {8'h00, e_step};
  endfunction
  function automatic logic [15:0] exp_data(input int n);
    logic [21:0] lo;
    lo = e_src[21:0] + 22'(n);
    if (e_mode == 0) return hfun({e_src[22], lo});
    if (e_mode == 1) return e_fill;
    return vfun(e_src[15:0] + 16'(n));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    hack <= 1'b0; vack <= 1'b0; wack <= 1'b0;
    if (hreq && ($urandom % 100) < ack_pct) begin
      hrdata <= hfun(haddr); hack <= 1'b1;
    end
    if (vreq && ($urandom % 100) < ack_pct) begin
      vrdata <= vfun(vaddr); vack <= 1'b1;
    end
    if (wreq && ($urandom % 100) < ack_pct) begin
      wack <= 1'b1;
      wr_count++;
      if (waddr !== exp_addr(idx) || wdata !== exp_data(idx)) begin
        if (werr == 0)
          $display("  word %0d: addr=%h/%h data=%h/%h", idx, waddr, exp_addr(idx), wdata, exp_data(idx));
        werr++;
      end
      idx++;
    end
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wreg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rreg(input logic [4:0] a, output logic [7:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic run_xfer(input int md, input int L, input logic [15:0] dst,
                          input logic [7:0] stp, input logic [22:0] s,
                          input logic [15:0] fillw, input bit poke);
    logic [7:0] r0, r1, r2; logic [22:0] es; int Le; logic [7:0] hi;
    Le = (L == 0) ? 65536 : L;
    hi = (md == 0) ? {1'b0, s[22:16]} : {1'b1, (md == 2), s[21:16]};
    e_mode = md; e_dest = dst; e_step = stp; e_fill = fillw;
    e_src = (md == 0) ? s : {(md == 2), s[21:0]};
    wreg(5'h0F, stp); wreg(5'h13, 8'(L)); wreg(5'h14, 8'(L >> 8));
    wreg(5'h15, s[7:0]); wreg(5'h16, s[15:8]); wreg(5'h17, hi);
    idx = 0; werr = 0;
    @(negedge clk); cmd_we = 1; cmd_dest = dst;
    @(negedge clk); cmd_we = 0;
    check(busy === 1'b1, "R4", "busy after start", busy, 1);
    if (md == 1) begin
      repeat (4) @(negedge clk);
      check(idx == 0 && busy, "R7", "no write before fill word", idx, 0);
      data_we = 1; data_wdata = fillw;
      @(negedge clk); data_we = 0;
    end
    while (busy) begin
      if (poke && ($urandom % 4) == 0) begin
        reg_we = 1; reg_addr = 5'h13; reg_wdata = 8'($urandom);
        @(negedge clk); reg_we = 0;
      end else begin
        // R4: a second start while running is ignored
        if (($urandom % 16) == 0) begin cmd_we = 1; cmd_dest = 16'($urandom); end
        @(negedge clk); cmd_we = 0;
      end
    end
    check(idx == Le && werr == 0, md == 0 ? "R6/R5/R1" : md == 1 ? "R7/R5/R1" : "R8/R5/R1",
          "words written (count, errors)", {idx, werr}, {Le, 0});
    rreg(5'h13, r0); rreg(5'h14, r1);
    check({r1, r0} == 16'h0, "R9 R10", "count after run", {r1, r0}, 0);
    if (md == 0)      es = {e_src[22], e_src[21:0] + 22'(Le)};
    else if (md == 2) es = {e_src[22:16], e_src[15:0] + 16'(Le)};
    else              es = e_src;
    rreg(5'h15, r0); rreg(5'h16, r1); rreg(5'h17, r2);
    check({r2, r1, r0} == {hi[7], es}, "R9 R2", "source after run", {r2, r1, r0}, {hi[7], es});
  endtask

  initial begin
    int seed;
    logic [7:0] rd;
    seed = $urandom(32'h5EED1);
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; reg_raddr = 0;
    cmd_we = 0; cmd_dest = 0; data_we = 0; data_wdata = 0;
    hack = 0; vack = 0; wack = 0; hrdata = 0; vrdata = 0;
    e_mode = 1; e_dest = 0; e_step = 0; e_src = 0; e_fill = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    rreg(5'h13, rd);
    check(busy === 0 && wreq === 0 && hreq === 0 && vreq === 0, "R4", "reset outputs", busy, 0);
    check(rd == 8'h00, "R1", "count reg at reset", rd, 0);

    // R3: start ignored while disabled
    wreg(5'h13, 8'd3); wreg(5'h17, 8'h80);
    @(negedge clk); cmd_we = 1; @(negedge clk); cmd_we = 0;
    repeat (6) @(negedge clk);
    check(busy === 0 && wr_count == 0, "R3", "start with enable clear", wr_count, 0);
    wreg(5'h01, 8'h10);

    // R7: data write while idle does nothing
    @(negedge clk); data_we = 1; data_wdata = 16'hBEEF; @(negedge clk); data_we = 0;
    repeat (4) @(negedge clk);
    check(busy === 0 && wr_count == 0, "R7", "data write while idle", wr_count, 0);

    // directed corners
    run_xfer(0, 5, 16'hFFFC, 8'd2, 23'h7FFFFE, 0, 1);   // R6 wrap in low 22 bits, bit 22 kept
    run_xfer(2, 4, 16'h0100, 8'd0, 23'h00FFFE, 0, 0);   // R8 wrap, step 0
    run_xfer(1, 3, 16'h0010, 8'hFF, 23'h012345, 16'hA5A5, 1);
    for (int k = 0; k < 12; k++)
      run_xfer(int'($urandom % 3), int'(1 + $urandom % 24), 16'($urandom), 8'($urandom),
               23'($urandom), 16'($urandom), bit'($urandom % 2));
    ack_pct = 100;
    run_xfer(1, 0, 16'h2000, 8'd2, 23'h0, 16'h1234, 0);  // R1 zero count = 65536
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule